// File: doc/BRIEF.md
# MDIO Command Register Engine

This block is a management-interface master for Ethernet PHYs. Software drives it through one 32-bit word. A single write to that word supplies the operation, the PHY and register addresses, the data for a write, and a start bit. The engine then sends one clause-22 management frame on MDC/MDIO. While the frame runs, the start bit reads back as a busy flag. The flag clears by itself when the frame ends.

After a read frame completes, the value returned by the PHY sits in the low half of the same word, so polling software gets its answer from the register it was already watching. MDC is made from the system clock by a parameterized divider. A full frame takes 64 MDC periods, which is far inside a 10 ms software polling window at any normal divider setting. MDIO is presented as separate output, output-enable and input pins, for connection to a pad tri-state.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset, busy reads 0, MDC is low, the MDIO output enable is low, and the command word reads back as all zeros.
- R2: The command word uses these fields: bit 29 is start/busy, bit 27 selects a read, bit 26 marks a write, bits 25:21 are the PHY address, bits 20:16 are the register address, and bits 15:0 are the data. Read takes precedence whenever bit 27 is set; otherwise the operation is a write. Writing the word while idle stores it, and it reads back unchanged with bit 29 showing busy.
- R3: A write made while idle with bit 29 set starts one frame. Busy reads 1 from the next cycle, stays 1 for exactly 128·HALF_DIV clock cycles, and then clears by itself.
- R4: While busy, MDC is low for HALF_DIV cycles and then high for HALF_DIV cycles, starting low at launch. MDC stays low whenever the engine is idle.
- R5: A write frame sends, MSB first and one bit per MDC period: 32 ones, then 01, then opcode 01, then the PHY address, then the register address, then turnaround 10, then the 16 data bits. MDIO changes only while MDC is low.
- R6: A read frame uses opcode 10. The output enable is high for the first 46 bits of the frame and low from the turnaround to the end of the frame. The output enable is low whenever the engine is idle.
- R7: On a read, MDIO is sampled on the rising MDC edge of each of the 16 data bits, MSB first. After completion, bits 15:0 of the word hold the sampled value and bits 31:16 keep the values that were written.
- R8: A write to the command word while busy is ignored. It does not change the word, the frame in progress or busy, and a start bit in it launches nothing.
- R9: A write made while idle with bit 29 clear stores the word but starts no frame: busy stays 0 and MDC stays low.
- R10: A new start is accepted in the first cycle in which busy reads 0 after a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdWrEn | input | 1 | Write strobe for the command word |
| cmdWrData | input | 32 | Value written to the command word |
| cmdRdData | output | 32 | Current command word, with bit 29 showing busy |
| mdc | output | 1 | Management clock to the PHY |
| mdioOut | output | 1 | Management data driven toward the PHY |
| mdioOe | output | 1 | High when the engine drives MDIO |
| mdioIn | input | 1 | Management data sampled from the pad |

## Verification
The bench builds the engine with HALF_DIV = 2, so one frame lasts 256 system clocks. With that setting, several write frames, several read frames, a write made mid-frame and a back-to-back pair of launches all fit in a short run. Each cycle is compared against a behavioural model that predicts every MDC phase, every driven MDIO bit and the instant the driver is released. Because the half-period is two cycles rather than one, the bench can distinguish the cycles in which MDC holds its level from the cycles in which it toggles.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS  = 64;
  localparam int BUSY_BIT    = 29;
  localparam int RD_BIT      = 27;
  localparam int WR_BIT      = 26;
  localparam int PHY_LSB     = 21;
  localparam int REG_LSB     = 16;
  localparam int RELEASE_IDX = 46;  // first bit not driven on a read
  localparam int DATA_IDX    = 48;  // first data bit of the frame

  typedef struct packed {
    logic load;     // accept a new command and launch a frame
    logic shift;    // advance to the next frame bit (MDC falling)
    logic capture;  // sample MDIO (MDC rising, read data bits)
    logic done;     // frame finished
    logic drive;    // master owns MDIO this bit
  } mdioStrobes_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 25
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdWrEn,
  input  logic         startBit,
  input  logic         readBit,
  output logic         busy,
  output logic         mdc,
  output mdioStrobes_t strobes
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int IDX_W = $clog2(FRAME_BITS);

  logic [DIV_W-1:0] divCnt;
  logic [IDX_W-1:0] bitIdx;
  logic             busyR;
  logic             mdcR;
  logic             isRead;
  logic             tick;
  logic             lastBit;

  assign tick    = busyR && (divCnt == DIV_W'(HALF_DIV - 1));
  assign lastBit = (bitIdx == IDX_W'(FRAME_BITS - 1));

  always_comb begin
    strobes.load    = cmdWrEn && startBit && !busyR;
    strobes.capture = tick && !mdcR && isRead && (bitIdx >= IDX_W'(DATA_IDX));
    strobes.shift   = tick && mdcR && !lastBit;
    strobes.done    = tick && mdcR && lastBit;
    strobes.drive   = busyR && !(isRead && (bitIdx >= IDX_W'(RELEASE_IDX)));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyR  <= 1'b0;
      mdcR   <= 1'b0;
      divCnt <= '0;
      bitIdx <= '0;
      isRead <= 1'b0;
    end else if (strobes.load) begin
      busyR  <= 1'b1;
      mdcR   <= 1'b0;
      divCnt <= '0;
      bitIdx <= '0;
      isRead <= readBit;
    end else if (busyR) begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (tick) mdcR <= ~mdcR;
      if (strobes.shift) bitIdx <= bitIdx + 1'b1;
      if (strobes.done) begin
        busyR <= 1'b0;
        mdcR  <= 1'b0;
      end
    end
  end

  assign busy = busyR;
  assign mdc  = mdcR;

  AST_MDC_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busyR |-> !mdcR);  // R4
  AST_MDC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busyR && !tick) |=> $stable(mdcR));  // R4
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.load, strobes.shift, strobes.capture, strobes.done}));  // R3
  AST_BUSY_LAUNCH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyR) |-> $past(cmdWrEn && startBit));  // R3
  AST_CAPTURE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |-> !strobes.drive);  // R6
endmodule

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdWrEn,
  input  logic [31:0]  cmdWrData,
  input  logic         mdioIn,
  input  logic         busy,
  input  mdioStrobes_t strobes,
  output logic [31:0]  cmdRdData,
  output logic         mdioOut,
  output logic         mdioOe
);
  logic [31:0]           cmdReg;
  logic [FRAME_BITS-1:0] frame;
  logic [15:0]           rxData;
  logic                  wantRead;
  logic [1:0]            opCode;
  logic [1:0]            turnBits;
  logic [15:0]           txData;

  assign wantRead = cmdWrData[RD_BIT];
  assign opCode   = wantRead ? 2'b10 : 2'b01;
  assign turnBits = wantRead ? 2'b11 : 2'b10;
  assign txData   = wantRead ? 16'hFFFF : cmdWrData[15:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg <= '0;
      frame  <= '1;
      rxData <= '0;
    end else begin
      if (cmdWrEn && !busy)
        cmdReg <= cmdWrData;
      else if (strobes.done && cmdReg[RD_BIT])
        cmdReg[15:0] <= rxData;

      if (strobes.load)
        frame <= {32'hFFFF_FFFF, 2'b01, opCode,
                  cmdWrData[PHY_LSB +: 5], cmdWrData[REG_LSB +: 5],
                  turnBits, txData};
      else if (strobes.shift)
        frame <= {frame[FRAME_BITS-2:0], 1'b1};

      if (strobes.capture)
        rxData <= {rxData[14:0], mdioIn};
    end
  end

  assign cmdRdData = {cmdReg[31:BUSY_BIT+1], busy, cmdReg[BUSY_BIT-1:0]};
  assign mdioOut   = frame[FRAME_BITS-1];
  assign mdioOe    = strobes.drive;

  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strobes.done) |=> $stable(cmdReg));  // R8
  AST_RESULT_KEEPS_FIELDS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.done |=> (cmdReg[31:16] == $past(cmdReg[31:16])));  // R7
  AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdioOe);  // R6
  AST_LOAD_PREAMBLE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> mdioOut);  // R5
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 25
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdWrEn,
  input  logic [31:0] cmdWrData,
  output logic [31:0] cmdRdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  mdioStrobes_t strobes;
  logic         busy;

  mdio_ctrl #(.HALF_DIV(HALF_DIV)) ctrlInst (
    .clk      (clk),
    .rstN     (rstN),
    .cmdWrEn  (cmdWrEn),
    .startBit (cmdWrData[BUSY_BIT]),
    .readBit  (cmdWrData[RD_BIT]),
    .busy     (busy),
    .mdc      (mdc),
    .strobes  (strobes)
  );

  mdio_dp dpInst (
    .clk       (clk),
    .rstN      (rstN),
    .cmdWrEn   (cmdWrEn),
    .cmdWrData (cmdWrData),
    .mdioIn    (mdioIn),
    .busy      (busy),
    .strobes   (strobes),
    .cmdRdData (cmdRdData),
    .mdioOut   (mdioOut),
    .mdioOe    (mdioOe)
  );
endmodule

// File: tb/mdio_cmd_engine_test.sv
module mdio_cmd_engine_test;
  localparam int H = 2;
  localparam int FRAME_CYC = 128 * H;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cmdWrEn;
  logic [31:0] cmdWrData;
  logic [31:0] cmdRdData;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioIn;

  int nCmp = 0;
  int nBad = 0;
  int wd = 0;
  bit cmpOn = 0;
  bit reported = 0;

  // reference model state
  bit          mBusy = 0;
  int          mK = 0;
  bit          mRead = 0;
  logic [31:0] mWord = '0;
  logic [15:0] mRx = '0;
  logic [15:0] resp = 16'h0000;

  always #2.5 clk = ~clk;  // 200 MHz

  mdio_cmd_engine #(.HALF_DIV(H)) uut (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData),
    .cmdRdData(cmdRdData), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe),
    .mdioIn(mdioIn)
  );

  function automatic logic expBit(input logic [31:0] w, input int b);
    if (b < 32) return 1'b1;
    if (b == 32) return 1'b0;
    if (b == 33) return 1'b1;
    if (b == 34) return w[27] ? 1'b1 : 1'b0;
    if (b == 35) return w[27] ? 1'b0 : 1'b1;
    if (b <= 40) return w[21 + (40 - b)];
    if (b <= 45) return w[16 + (45 - b)];
    if (b == 46) return 1'b1;
    if (b == 47) return 1'b0;
    return w[15 - (b - 48)];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    end
  endtask

  // model update
  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mK = 0; mRead = 0; mWord = '0; mRx = '0;
    end else if (mBusy) begin
      if ((mK % H == H - 1) && ((mK / H) % 2 == 0) && mRead && (mK / (2 * H) >= 48))
        mRx = {mRx[14:0], mdioIn};
      if (mK == FRAME_CYC - 1) begin
        mBusy = 0;
        if (mRead) mWord[15:0] = mRx;
      end else mK++;
    end else if (cmdWrEn) begin
      mWord = cmdWrData;
      if (cmdWrData[29]) begin
        mBusy = 1; mK = 0; mRead = cmdWrData[27];
      end
    end
  end

  // per-cycle comparison and PHY response
  always @(negedge clk) begin
    int bitI;
    bitI = mK / (2 * H);
    if (cmpOn) begin
      chk("R3 busy", {31'b0, cmdRdData[29]}, {31'b0, mBusy});
      chk("R4 mdc", {31'b0, mdc}, {31'b0, mBusy && ((mK / H) % 2 == 1)});
      chk("R6 oe", {31'b0, mdioOe}, {31'b0, mBusy && !(mRead && bitI >= 46)});
      if (mBusy && mdioOe)
        chk("R5 mdio bit", {31'b0, mdioOut}, {31'b0, expBit(mWord, bitI)});
      chk("R7 word", cmdRdData, {mWord[31:30], mBusy, mWord[28:0]});
    end
    mdioIn <= (mBusy && bitI >= 48) ? resp[15 - (bitI - 48)] : 1'b1;
  end

  always @(posedge clk) begin
    wd++;
    if (wd == 60000) begin
      nBad++;
      $display("FAIL R3 watchdog: actual hung expected finish");
      report();
      $finish;
    end
  end

  task automatic wr(input logic [31:0] w);
    cmdWrEn = 1'b1; cmdWrData = w;
    @(negedge clk);
    cmdWrEn = 1'b0;
  endtask

  task automatic waitIdle();
    while (cmdRdData[29]) @(negedge clk);
  endtask

  function automatic logic [31:0] mkCmd(input bit rd, input logic [4:0] phy,
                                        input logic [4:0] rg, input logic [15:0] d);
    return {2'b00, 1'b1, 1'b0, rd, !rd, phy, rg, d};
  endfunction

  initial begin
    logic [31:0] w;
    rstN = 1'b0; cmdWrEn = 1'b0; cmdWrData = '0; mdioIn = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset word", cmdRdData, 32'h0);
    chk("R1 reset pins", {29'b0, mdc, mdioOe, cmdRdData[29]}, 32'h0);
    cmpOn = 1;

    // write frame, with an ignored write in the middle
    w = mkCmd(0, 5'h13, 5'h0A, 16'hA55A);
    wr(w);
    repeat (40) @(negedge clk);
    wr(mkCmd(1, 5'h01, 5'h1F, 16'h1234));
    chk("R8 ignored write", cmdRdData, w);
    waitIdle();
    chk("R2 stored fields", cmdRdData, w & ~32'h2000_0000);

    // read frame
    resp = 16'hC3A5;
    w = mkCmd(1, 5'h01, 5'h02, 16'h0000);
    wr(w);
    waitIdle();
    chk("R7 read result", cmdRdData, {w[31:30], 1'b0, w[28:16], 16'hC3A5});

    // store without start
    wr(32'h0C00_BEEF);
    repeat (5) @(negedge clk);
    chk("R9 no launch", {30'b0, mdc, cmdRdData[29]}, 32'h0);
    chk("R9 stored", cmdRdData, 32'h0C00_BEEF);

    // back-to-back launches
    resp = 16'h0001;
    wr(mkCmd(1, 5'h1F, 5'h1F, 16'h0000));
    waitIdle();
    chk("R7 second read", {16'h0, cmdRdData[15:0]}, 32'h0001);
    wr(mkCmd(0, 5'h00, 5'h00, 16'h8001));
    chk("R10 relaunch busy", {31'b0, cmdRdData[29]}, 32'h1);
    waitIdle();
    resp = 16'hFFFF;
    wr(mkCmd(1, 5'h0F, 5'h10, 16'h0000));
    waitIdle();
    chk("R7 third read", {16'h0, cmdRdData[15:0]}, 32'hFFFF);
    repeat (4) @(negedge clk);

    report();
    $finish;
  end
endmodule